// File: doc/BRIEF.md
# Voice PCM Serial Port

This block is a full-duplex serial port that moves one 16-bit voice sample in each direction per frame between the chip and a host processor. The bit clock and the 8 kHz frame sync both come from outside. The block samples them with its own system clock and detects their edges there. A frame begins on the first falling bit-clock edge after the frame sync becomes active.

At that edge the block latches the parallel transmit word and pulses a load strobe. After a programmable number of bit clocks, it shifts the word out MSB first on the serial output. In the same slot it shifts in the serial input. When the last bit has been captured, it presents the received word with a one-cycle valid strobe.

Configuration inputs set three things: the active level of the frame sync, a data delay of 0 to 15 bit clocks, and whether each data bit lasts one or two bit-clock periods. The delay and the bit mode are taken at the start of each frame.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, the serial output is 0 and neither the load strobe nor the receive valid strobe is asserted.
- R2: A frame starts on the first falling bit-clock edge after an inactive-to-active change of the frame sync. At that edge the transmit word is latched and the load strobe pulses for exactly one cycle per frame.
- R3: The latched transmit word (16-bit two's complement) is driven on the serial output MSB first. Each bit changes after a falling bit-clock edge.
- R4: Serial input bits are captured on rising bit-clock edges, MSB first. After the 16th bit, the received word appears with a valid strobe that lasts exactly one cycle, once per frame.
- R5: With a delay value D (0 to 15), the MSB is driven after the D-th falling edge that follows the frame-start edge. With D = 0, the MSB is driven at the frame-start edge itself.
- R6: With the double mode bit set, each data bit lasts two bit-clock periods. It is driven at the first of its two falling edges and sampled at the second of its two rising edges. With the bit clear (the default), each data bit lasts one period.
- R7: With the polarity input set to 1 (the default), a frame is opened by a low-to-high change of the frame sync. With the polarity input at 0, a frame is opened by a high-to-low change.
- R8: The serial output is 0 outside the 16-bit slot, both during the delay and after the LSB.
- R9: Changes to the transmit word, the delay or the bit mode after a frame has started have no effect on that frame.
- R10: A bit clock that runs while the frame sync stays inactive opens no frame. No load strobe or valid strobe is produced, and the output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External 8 kHz frame sync |
| sdin_i | input | 1 | Serial receive data |
| cfg_fs_high_i | input | 1 | 1: frame sync active high, 0: active low |
| cfg_delay_i | input | 4 | Data delay in bit clocks |
| cfg_dbl_i | input | 1 | 1: two bit-clock periods per data bit |
| tx_word_i | input | 16 | Transmit sample |
| tx_load_o | output | 1 | Pulse when the transmit sample is latched |
| sdout_o | output | 1 | Serial transmit data |
| rx_word_o | output | 16 | Last received sample |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o is updated |

## Verification
The hardest situation to reach is a configuration change in the middle of a running frame. To reach it, one scenario flips the transmit word, the delay and the bit mode two bit clocks after the frame start. It then checks that the serial output and the captured word still follow the values present at frame start, and that the stray-bit count outside the slot stays zero. The slot edges at the largest delay (15) and in double mode also get their own frames. In these frames the bench drives ones on the input outside the slot, so that any misaligned capture corrupts the received word.

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
  parameter int W  = 16,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          fsync_i,
  input  logic          sdin_i,
  input  logic          cfg_fs_high_i,
  input  logic [DW-1:0] cfg_delay_i,
  input  logic          cfg_dbl_i,
  input  logic [W-1:0]  tx_word_i,
  output logic          tx_load_o,
  output logic          sdout_o,
  output logic [W-1:0]  rx_word_o,
  output logic          rx_valid_o
);
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {IDLE, WAIT, SLOT} phase_t;

  phase_t        phase;
  logic          bclk_q, bclk_p, sdin_q, fs_q, fs_p, armed;
  logic [DW-1:0] dcnt;
  logic [CW-1:0] bit_cnt;
  logic          sub, dbl_q;
  logic [W-1:0]  tx_sh;
  logic [W-2:0]  rx_sh;
  logic          sdout_q, tx_load_q, rx_valid_q;
  logic [W-1:0]  rx_word_q;

  logic fall, rise, fs_edge, start, last_sub, last_bit, busy;

  assign fall     = bclk_p & ~bclk_q;
  assign rise     = ~bclk_p & bclk_q;
  assign fs_edge  = fs_q & ~fs_p;
  assign start    = fall & armed;
  assign last_sub = ~dbl_q | sub;
  assign last_bit = bit_cnt == CW'(W - 1);
  assign busy     = phase != IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      bclk_p     <= 1'b0;
      sdin_q     <= 1'b0;
      fs_q       <= 1'b0;
      fs_p       <= 1'b0;
      armed      <= 1'b0;
      phase      <= IDLE;
      dcnt       <= '0;
      bit_cnt    <= '0;
      sub        <= 1'b0;
      dbl_q      <= 1'b0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      sdout_q    <= 1'b0;
      tx_load_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_word_q  <= '0;
    end else begin
      bclk_q     <= bclk_i;
      bclk_p     <= bclk_q;
      sdin_q     <= sdin_i;
      fs_q       <= cfg_fs_high_i ? fsync_i : ~fsync_i;
      fs_p       <= fs_q;
      tx_load_q  <= 1'b0;
      rx_valid_q <= 1'b0;

      if (fs_edge)     armed <= 1'b1;
      else if (start)  armed <= 1'b0;

      if (start) begin
        tx_load_q <= 1'b1;
        dbl_q     <= cfg_dbl_i;
        sub       <= 1'b0;
        bit_cnt   <= '0;
        if (cfg_delay_i == '0) begin
          phase   <= SLOT;
          sdout_q <= tx_word_i[W-1];
          tx_sh   <= {tx_word_i[W-2:0], 1'b0};
        end else begin
          phase   <= WAIT;
          dcnt    <= cfg_delay_i;
          sdout_q <= 1'b0;
          tx_sh   <= tx_word_i;
        end
      end else if (fall) begin
        case (phase)
          WAIT: begin
            dcnt <= dcnt - DW'(1);
            if (dcnt == DW'(1)) begin
              phase   <= SLOT;
              sdout_q <= tx_sh[W-1];
              tx_sh   <= {tx_sh[W-2:0], 1'b0};
            end
          end
          SLOT: begin
            if (last_sub) begin
              sub <= 1'b0;
              if (last_bit) begin
                phase   <= IDLE;
                sdout_q <= 1'b0;
              end else begin
                bit_cnt <= bit_cnt + CW'(1);
                sdout_q <= tx_sh[W-1];
                tx_sh   <= {tx_sh[W-2:0], 1'b0};
              end
            end else begin
              sub <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (rise && phase == SLOT && last_sub) begin
        rx_sh <= {rx_sh[W-3:0], sdin_q};
        if (last_bit) begin
          rx_word_q  <= {rx_sh, sdin_q};
          rx_valid_q <= 1'b1;
        end
      end
    end
  end

  assign tx_load_o  = tx_load_q;
  assign sdout_o    = sdout_q;
  assign rx_word_o  = rx_word_q;
  assign rx_valid_o = rx_valid_q;
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fall,
  input logic rise,
  input logic start,
  input logic busy,
  input logic dbl_q,
  input logic sdout_o,
  input logic tx_load_o,
  input logic rx_valid_o
);
  // R2
  load_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |-> $past(fall));

  // R2
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |=> !tx_load_o);

  // R3
  sdout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_o) |-> $past(fall));

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R4
  rx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(rise));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdout_o);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start)) |-> $stable(dbl_q));
endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fall       (fall),
  .rise       (rise),
  .start      (start),
  .busy       (busy),
  .dbl_q      (dbl_q),
  .sdout_o    (sdout_o),
  .tx_load_o  (tx_load_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/sim_pcm_voice_port.sv
module sim_pcm_voice_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1, fsync = 1'b0, sdin = 1'b0;
  logic        cfg_fs_high = 1'b1, cfg_dbl = 1'b0;
  logic [3:0]  cfg_delay = 4'd0;
  logic [15:0] tx_word = 16'h0;
  logic        tx_load, sdout, rx_valid;
  logic [15:0] rx_word;

  int checks = 0, errors = 0;
  int loads = 0, rxs = 0;
  logic [15:0] rx_cap = 16'h0;

  always #5 clk = ~clk;

  pcm_voice_port u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
    .cfg_fs_high_i(cfg_fs_high), .cfg_delay_i(cfg_delay), .cfg_dbl_i(cfg_dbl),
    .tx_word_i(tx_word), .tx_load_o(tx_load), .sdout_o(sdout),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_load) loads <= loads + 1;
      if (rx_valid) begin
        rxs    <= rxs + 1;
        rx_cap <= rx_word;
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] txw, input logic [15:0] rxw, input int dly,
                           input logic dbl, input logic pol, input logic mid, input string req);
    int per, last, lb, rb, stray;
    logic [15:0] got;
    per = dbl ? 2 : 1;
    stray = 0;
    got = 16'h0;
    cfg_fs_high = pol; cfg_delay = dly[3:0]; cfg_dbl = dbl; tx_word = txw;
    fsync = ~pol; bclk = 1'b1; sdin = 1'b1;
    repeat (6) @(negedge clk);
    lb = loads; rb = rxs;
    fsync = pol;
    repeat (3) @(negedge clk);
    last = dly + 16 * per + 2;
    for (int n = 0; n <= last; n++) begin
      bclk = 1'b0;
      if (n >= dly && n < dly + 16 * per) sdin = rxw[15 - (n - dly) / per];
      else sdin = 1'b1;
      if (n == 1) fsync = ~pol;
      if (mid && n == 2) begin
        tx_word = ~txw; cfg_dbl = ~dbl; cfg_delay = ~dly[3:0];
      end
      repeat (4) @(negedge clk);
      if (n >= dly && n < dly + 16 * per) begin
        if ((n - dly) % per == 0) got[15 - (n - dly) / per] = sdout;
      end else if (sdout !== 1'b0) stray++;
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(got == txw, {req, " tx bits R3"}, got, txw);
    check(stray == 0, {req, " quiet outside slot R8"}, stray, 0);
    check(loads - lb == 1, {req, " one load strobe R2"}, loads - lb, 1);
    check(rxs - rb == 1, {req, " one rx strobe R4"}, rxs - rb, 1);
    check(rx_cap == rxw, {req, " rx word R4"}, rx_cap, rxw);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check(sdout === 1'b0 && tx_load === 1'b0 && rx_valid === 1'b0, "R1 reset state",
          {sdout, tx_load, rx_valid}, 0);
  endtask

  task automatic t_basic;
    run_frame(16'hA5C3, 16'h3C5A, 0, 1'b0, 1'b1, 1'b0, "R2 basic");
    run_frame(16'h8001, 16'h7FFE, 0, 1'b0, 1'b1, 1'b0, "R3 extremes");
  endtask

  task automatic t_delay;
    run_frame(16'h1234, 16'hFEDC, 5, 1'b0, 1'b1, 1'b0, "R5 delay5");
    run_frame(16'hFFFF, 16'h0001, 15, 1'b0, 1'b1, 1'b0, "R5 delay15");
  endtask

  task automatic t_double;
    run_frame(16'hC0DE, 16'hBEEF, 3, 1'b1, 1'b1, 1'b0, "R6 double");
    run_frame(16'h5555, 16'hAAAA, 0, 1'b1, 1'b1, 1'b0, "R6 double d0");
  endtask

  task automatic t_polarity;
    run_frame(16'h0F0F, 16'hF00F, 2, 1'b0, 1'b0, 1'b0, "R7 active low");
  endtask

  task automatic t_midchange;
    run_frame(16'h9A5B, 16'h6C7D, 4, 1'b0, 1'b1, 1'b1, "R9 mid change");
    run_frame(16'h2468, 16'h1357, 1, 1'b1, 1'b1, 1'b1, "R9 mid change dbl");
  endtask

  task automatic t_nosync;
    int lb, rb, stray;
    stray = 0;
    cfg_fs_high = 1'b1; fsync = 1'b0; sdin = 1'b1; tx_word = 16'hFFFF; cfg_delay = 4'd0;
    repeat (6) @(negedge clk);
    lb = loads; rb = rxs;
    for (int n = 0; n < 40; n++) begin
      bclk = 1'b0; repeat (4) @(negedge clk);
      if (sdout !== 1'b0) stray++;
      bclk = 1'b1; repeat (4) @(negedge clk);
    end
    check(loads == lb, "R10 no load without sync", loads - lb, 0);
    check(rxs == rb, "R10 no rx without sync", rxs - rb, 0);
    check(stray == 0, "R10 output quiet without sync", stray, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_nosync;
    t_basic;
    t_delay;
    t_double;
    t_polarity;
    t_midchange;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule